// File: doc/BRIEF.md
# Sector Page-Load Program Sequencer

This block is the control core of a byte-wide flash-style memory model that is rewritten one whole sector at a time. A bus front-end hands it byte-load strobes, each with an address and data already latched. The low address bits pick a byte within a 256-byte sector and the upper bits pick the sector. Loads gather in a page buffer and may arrive in any order. The load period stays open while each new load follows the previous accepted one within a timeout. When a timeout passes with no load, the block holds the buffered bytes and the sector internally and starts a timed internal cycle. That cycle first erases every byte of the sector to all-ones, then writes in the bytes that were loaded.

While the internal cycle runs, the busy output is high and a read returns a status word instead of array data. In that word, the top bit is the inverse of the top bit of the last byte accepted, and the other bits are zero. After the cycle ends, reads return array contents again. Bytes of the sector that were not loaded read back as all-ones. The load timeout and the total cycle length are parameters counted in clock cycles. By default they match 150 µs and 10 ms at a 50 MHz clock. The sector-address width is also a parameter. Its default is small so that the behavioural array stays at a modest size.

Top module: `sector_page_programmer`

## Requirements
- R1: While reset is high and on the first cycle after it, busy is 0 and rd_data is 0.
- R2: A load address is split into a byte index (bits BYTE_AW-1..0) and a sector number (the bits above). After programming, each loaded byte sits at that byte of that sector, whatever the order of the loads.
- R3: A load whose strobe arrives TIMEOUT_CYC cycles or fewer after the previous accepted load joins the same load period.
- R4: busy rises exactly TIMEOUT_CYC cycles after the strobe of the last accepted load, if no further accepted load comes in between.
- R5: During a load period, a load to a sector other than the one that opened the period is ignored. It neither writes the buffer nor restarts the timeout.
- R6: Loads presented while busy is high are ignored. They reach neither the buffer nor the array, and they do not open a new load period.
- R7: busy stays high for exactly WRITE_CYC cycles per internal cycle.
- R8: A read issued while busy is high returns bit DATA_W-1 equal to the inverse of bit DATA_W-1 of the last accepted byte, and all other bits 0.
- R9: After the cycle, every loaded byte reads back its loaded value, and every byte of that sector that was not loaded reads all-ones.
- R10: Sectors other than the programmed one keep their contents across an internal cycle. Bytes never programmed read all-ones.
- R11: rd_data changes only on the cycle after an rd_en. It holds its value otherwise.
- R12: The buffer is emptied after each cycle. A byte loaded in an earlier period but not in the current one reads all-ones after the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | One-cycle byte-load strobe |
| ld_addr | input | SECTOR_AW+BYTE_AW | Latched load address: sector number above byte index |
| ld_data | input | DATA_W | Latched load data |
| rd_en | input | 1 | Read request, answered on the next cycle |
| rd_addr | input | SECTOR_AW+BYTE_AW | Read address |
| rd_data | output | DATA_W | Array data or, while busy, the polling word |
| busy | output | 1 | High during the internal erase-and-write cycle |

## Verification
The bench builds the block with TIMEOUT_CYC = 16 and WRITE_CYC = 600, and keeps BYTE_AW = 8 and SECTOR_AW = 2. These values let the run reach the timeout boundary on both sides, with a load exactly on the last allowed cycle and one a cycle late. They also let the run measure full internal cycles to the exact cycle, and repeat the cycle three times across different sectors within a few thousand clocks. The full 256-byte sector width stays intact, so the erase sweep and write sweep cover every byte index.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ERASE,
    ST_WRITE,
    ST_SETTLE
  } seq_state_t;
endpackage

// File: rtl/sps_window_timer.sv
module sps_window_timer #(
  parameter int TIMEOUT_CYC = 7500
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign expire = run && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/sps_page_buf.sv
module sps_page_buf #(
  parameter int DATA_W  = 8,
  parameter int BYTE_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               we,
  input  logic [BYTE_AW-1:0] waddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               re,
  input  logic [BYTE_AW-1:0] raddr,
  output logic [DATA_W-1:0]  rdata,
  output logic               rflag
);
  localparam int PAGE = 1 << BYTE_AW;

  logic [DATA_W-1:0] mem [PAGE];
  logic [PAGE-1:0]   filled_q;

  // data storage: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

  // per-byte "loaded" marks
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      filled_q <= '0;
    end else if (we) begin
      filled_q[waddr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rflag <= 1'b0;
    end else if (re) begin
      rflag <= filled_q[raddr];
    end
  end
endmodule

// File: rtl/sps_flash_array.sv
module sps_flash_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // power-up content is the erased state
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      cells[i] = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= cells[raddr];
    end
  end
endmodule

// File: rtl/sector_page_programmer.sv
module sector_page_programmer
  import sps_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BYTE_AW     = 8,
  parameter int SECTOR_AW   = 2,
  parameter int TIMEOUT_CYC = 7500,
  parameter int WRITE_CYC   = 500000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld_stb,
  input  logic [SECTOR_AW+BYTE_AW-1:0] ld_addr,
  input  logic [DATA_W-1:0]            ld_data,
  input  logic                         rd_en,
  input  logic [SECTOR_AW+BYTE_AW-1:0] rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         busy
);
  localparam int PAGE   = 1 << BYTE_AW;
  localparam int ADDR_W = SECTOR_AW + BYTE_AW;
  localparam int CYC_W  = $clog2(WRITE_CYC + 1);

  initial begin
    if (WRITE_CYC < 2 * PAGE + 1) $error("WRITE_CYC too short for erase and write sweeps");
    if (TIMEOUT_CYC < 1) $error("TIMEOUT_CYC must be at least 1");
  end

  seq_state_t state_q, state_d;

  logic [SECTOR_AW-1:0] sec_q;
  logic [CYC_W-1:0]     cyc_q;
  logic                 last_b7_q;
  logic                 busy_q;
  logic                 wr_pend_q;
  logic [BYTE_AW-1:0]   wr_idx_q;
  logic                 poll_q;
  logic                 poll_bit_q;

  logic [SECTOR_AW-1:0] ld_sec;
  logic [BYTE_AW-1:0]   ld_byte;
  logic                 ld_ok;
  logic                 tmr_expire;
  logic                 in_cycle_d;

  logic [DATA_W-1:0]    buf_rdata;
  logic                 buf_rflag;
  logic                 buf_re;
  logic                 buf_clr;

  logic                 arr_we;
  logic [ADDR_W-1:0]    arr_waddr;
  logic [DATA_W-1:0]    arr_wdata;
  logic [DATA_W-1:0]    arr_rdata;

  assign ld_sec  = ld_addr[ADDR_W-1:BYTE_AW];
  assign ld_byte = ld_addr[BYTE_AW-1:0];

  // a load is taken when idle, or when loading into the same sector
  assign ld_ok = ld_stb &&
                 ((state_q == ST_IDLE) ||
                  ((state_q == ST_LOAD) && (ld_sec == sec_q)));

  sps_window_timer #(
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .restart(ld_ok),
    .run    (state_q == ST_LOAD),
    .expire (tmr_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (ld_ok) state_d = ST_LOAD;
      ST_LOAD:   if (!ld_ok && tmr_expire) state_d = ST_ERASE;
      ST_ERASE:  if (cyc_q == CYC_W'(PAGE - 1)) state_d = ST_WRITE;
      ST_WRITE:  if (cyc_q == CYC_W'(2 * PAGE - 1)) state_d = ST_SETTLE;
      ST_SETTLE: if (cyc_q == CYC_W'(WRITE_CYC - 1)) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign in_cycle_d = (state_d == ST_ERASE) || (state_d == ST_WRITE) ||
                      (state_d == ST_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      busy_q    <= 1'b0;
      cyc_q     <= '0;
      sec_q     <= '0;
      last_b7_q <= 1'b0;
      wr_pend_q <= 1'b0;
      wr_idx_q  <= '0;
    end else begin
      state_q   <= state_d;
      busy_q    <= in_cycle_d;
      if (state_q == ST_LOAD) begin
        cyc_q <= '0;
      end else if (busy_q) begin
        cyc_q <= cyc_q + CYC_W'(1);
      end
      if (ld_ok && (state_q == ST_IDLE)) begin
        sec_q <= ld_sec;
      end
      if (ld_ok) begin
        last_b7_q <= ld_data[DATA_W-1];
      end
      wr_pend_q <= (state_q == ST_WRITE);
      wr_idx_q  <= cyc_q[BYTE_AW-1:0];
    end
  end

  // page buffer: read one entry per cycle during the write sweep
  assign buf_re  = (state_q == ST_WRITE);
  assign buf_clr = (state_q == ST_SETTLE) && (state_d == ST_IDLE);

  sps_page_buf #(
    .DATA_W (DATA_W),
    .BYTE_AW(BYTE_AW)
  ) u_buf (
    .clk  (clk),
    .rst  (rst),
    .clr  (buf_clr),
    .we   (ld_ok),
    .waddr(ld_byte),
    .wdata(ld_data),
    .re   (buf_re),
    .raddr(cyc_q[BYTE_AW-1:0]),
    .rdata(buf_rdata),
    .rflag(buf_rflag)
  );

  // single array write port: erase sweep first, then buffered data
  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = {sec_q, wr_idx_q};
    arr_wdata = '1;
    if (state_q == ST_ERASE) begin
      arr_we    = 1'b1;
      arr_waddr = {sec_q, cyc_q[BYTE_AW-1:0]};
    end else if (wr_pend_q) begin
      arr_we    = 1'b1;
      arr_wdata = buf_rflag ? buf_rdata : '1;
    end
  end

  sps_flash_array #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_array (
    .clk  (clk),
    .rst  (rst),
    .we   (arr_we),
    .waddr(arr_waddr),
    .wdata(arr_wdata),
    .re   (rd_en && !busy_q),
    .raddr(rd_addr),
    .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_q     <= 1'b0;
      poll_bit_q <= 1'b0;
    end else if (rd_en) begin
      poll_q     <= busy_q;
      poll_bit_q <= ~last_b7_q;
    end
  end

  assign rd_data = poll_q ? {poll_bit_q, {(DATA_W-1){1'b0}}} : arr_rdata;
  assign busy    = busy_q;
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int DATA_W      = 8,
  parameter int TIMEOUT_CYC = 7500,
  parameter int WRITE_CYC   = 500000
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              ld_ok,
  input logic              last_b7
);
  logic [31:0] busy_cnt;
  logic [31:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (rst || ld_ok)                quiet_cnt <= '0;
    else if (quiet_cnt != '1)        quiet_cnt <= quiet_cnt + 32'd1;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) rst |=> !busy);

  assert_timeout_exact_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (quiet_cnt == 32'(TIMEOUT_CYC)));

  assert_no_load_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ld_ok);

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == 32'(WRITE_CYC)));

  assert_busy_bound_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt < 32'(WRITE_CYC)));

  assert_poll_word_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy) |=> (rd_data == {~$past(last_b7), {(DATA_W-1){1'b0}}}));

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rst)) |=> $stable(rd_data));
endmodule

bind sector_page_programmer sps_checker #(
  .DATA_W     (DATA_W),
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .WRITE_CYC  (WRITE_CYC)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .rd_en  (rd_en),
  .rd_data(rd_data),
  .ld_ok  (ld_ok),
  .last_b7(last_b7_q)
);

// File: tb/sector_page_programmer_tb.sv
module sector_page_programmer_tb;
  localparam int DATA_W  = 8;
  localparam int BYTE_AW = 8;
  localparam int SEC_AW  = 2;
  localparam int TMO     = 16;
  localparam int WCYC    = 600;
  localparam int AW      = SEC_AW + BYTE_AW;

  // stimulus table: {byte index, data}, all for sector 1, scrambled order
  localparam logic [15:0] LOAD_VEC [8] = '{
    16'h07_5A, 16'hF0_C3, 16'h00_11, 16'h80_E7,
    16'h3F_00, 16'hFF_81, 16'h41_7E, 16'h10_24
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ld_stb = 1'b0;
  logic [AW-1:0]     ld_addr = '0;
  logic [DATA_W-1:0] ld_data = '0;
  logic              rd_en = 1'b0;
  logic [AW-1:0]     rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              busy;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sector_page_programmer #(
    .DATA_W(DATA_W), .BYTE_AW(BYTE_AW), .SECTOR_AW(SEC_AW),
    .TIMEOUT_CYC(TMO), .WRITE_CYC(WCYC)
  ) u_dut (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic load(input logic [SEC_AW-1:0] sec, input logic [7:0] idx, input logic [7:0] d);
    ld_stb = 1'b1; ld_addr = {sec, idx}; ld_data = d;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic rd(input logic [SEC_AW-1:0] sec, input logic [7:0] idx, output logic [7:0] q);
    rd_en = 1'b1; rd_addr = {sec, idx};
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [7:0] held;
    int n;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 rd_data after reset", 32'(rd_data), 0);

    // ---- table-driven period on sector 1 ----
    for (int i = 0; i < 8; i++) load(2'd1, LOAD_VEC[i][15:8], LOAD_VEC[i][7:0]);
    n = 0;
    while (!busy) begin @(negedge clk); n++; end
    chk("R4 cycles to busy", n, TMO);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    chk("R7 busy length", n, WCYC);
    for (int i = 0; i < 8; i++) begin
      rd(2'd1, LOAD_VEC[i][15:8], q);
      chk("R2 R9 loaded byte readback", 32'(q), 32'(LOAD_VEC[i][7:0]));
    end
    rd(2'd1, 8'h55, q);
    chk("R9 unloaded byte is erased", 32'(q), 32'hFF);
    rd(2'd0, 8'h07, q);
    chk("R10 untouched sector erased", 32'(q), 32'hFF);

    // ---- sector 2, foreign-sector load, loads while busy, polling ----
    load(2'd2, 8'h10, 8'hA5);
    load(2'd2, 8'h11, 8'h3C);
    load(2'd3, 8'h20, 8'h9F);
    n = 0;
    while (!busy) begin @(negedge clk); n++; end
    chk("R5 foreign load does not restart timeout", n, TMO - 1);
    load(2'd2, 8'h12, 8'h77);
    load(2'd0, 8'h00, 8'h00);
    rd(2'd2, 8'h10, q);
    chk("R8 poll word", 32'(q), 32'h80);
    held = q;
    @(negedge clk);
    chk("R11 rd_data holds without rd_en", 32'(rd_data), 32'(held));
    wait_idle();
    repeat (TMO + 5) @(negedge clk);
    chk("R6 no new period from busy loads", 32'(busy), 0);
    rd(2'd2, 8'h10, q);  chk("R9 sector 2 byte 10", 32'(q), 32'hA5);
    rd(2'd2, 8'h11, q);  chk("R9 sector 2 byte 11", 32'(q), 32'h3C);
    rd(2'd2, 8'h12, q);  chk("R6 load during busy dropped", 32'(q), 32'hFF);
    rd(2'd0, 8'h00, q);  chk("R6 R10 sector 0 untouched", 32'(q), 32'hFF);
    rd(2'd3, 8'h20, q);  chk("R5 foreign sector byte unchanged", 32'(q), 32'hFF);
    rd(2'd1, 8'hF0, q);  chk("R10 sector 1 kept", 32'(q), 32'hC3);
    rd(2'd1, 8'h80, q);
    chk("R11 read after idle returns data", 32'(q), 32'hE7);

    // ---- window boundary on sector 2 and buffer clearing ----
    load(2'd2, 8'h30, 8'h01);
    repeat (TMO - 1) @(negedge clk);
    chk("R3 still loading at last allowed cycle", 32'(busy), 0);
    load(2'd2, 8'h31, 8'h02);
    repeat (TMO) @(negedge clk);
    chk("R4 busy one cycle after window", 32'(busy), 1);
    load(2'd2, 8'h40, 8'h33);
    wait_idle();
    rd(2'd2, 8'h30, q);  chk("R3 first byte", 32'(q), 32'h01);
    rd(2'd2, 8'h31, q);  chk("R3 byte at window edge accepted", 32'(q), 32'h02);
    rd(2'd2, 8'h40, q);  chk("R4 late byte rejected", 32'(q), 32'hFF);
    rd(2'd2, 8'h10, q);  chk("R12 stale buffer byte erased", 32'(q), 32'hFF);
    rd(2'd2, 8'h11, q);  chk("R12 stale buffer byte erased", 32'(q), 32'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule